// File: doc/BRIEF.md
# Triggered Latency Pipeline with Derandomizer

This block keeps one record for every bunch crossing: a hit bit and a 6-bit drift-time code for each of 32 detector channels. Each record goes into a circular buffer that is written once per clock, so the buffer supplies a fixed trigger latency of `LAT` crossings. With the default 160 slots and 25 ns crossings, that latency is 4.0 µs. A channel mask is applied as records are written. A masked channel stores no hit and a zero drift time.

A trigger strobe selects a window of one, two or three consecutive crossings. The window begins with the record that was stored exactly `LAT` crossings before the trigger. The block copies that window, one crossing per clock, into a derandomizing FIFO, and a downstream formatter drains the FIFO through a valid/ready interface. Each FIFO entry is one crossing, and flags mark the first and last crossing of an event. Bursts of triggers, up to an average rate of about 1.1 MHz, are absorbed by the FIFO.

If the FIFO cannot take a whole event, the trigger is discarded and a sticky overflow flag is raised. An input pulse clears the flag.

Top module: `otx_lat_pipe`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the ring pointer, the primed state, the FIFO and the overflow flag. After that edge, `ev_valid` and `ovf` are 0.
- R2: At every clock edge with `rst` low, the crossing on `xing_hits`/`xing_drift` is stored in the ring. Where `chan_mask[c]` = 1, channel c is stored with hit bit 0 and drift field `[6c+5:6c]` equal to 0. The drift code for channel c is at bits `[6c+5:6c]`.
- R3: Suppose a trigger is sampled at the edge that stores crossing x. Its event is then made of crossings x-LAT, x-LAT+1, … in that order. The crossing numbers wrap modulo LAT inside the ring.
- R4: `win_len` is sampled with the trigger and gives the event length. Codes 1, 2 and 3 select 1, 2 and 3 crossings, and code 0 selects 1 crossing.
- R5: A trigger that arrives before LAT crossings have been stored since reset is ignored. It produces no event and does not set the overflow flag.
- R6: A trigger that arrives while an earlier event is still being copied is ignored. The copy of an N-crossing event takes N clock edges.
- R7: In each event, `ev_first` is 1 only on the first crossing and `ev_last` is 1 only on the last crossing. A one-crossing event has both flags set.
- R8: The FIFO is first-word-fall-through and holds `EV_DEPTH*MAX_WIN` crossings. The head entry stays valid and unchanged while `ev_ready` is low.
- R9: If the FIFO has fewer free entries than the event needs, none of the event is queued and `ovf` becomes 1. `ovf` then stays 1 until it is cleared.
- R10: `ovf_clr` clears `ovf` at the next edge. If a trigger is dropped in the same cycle, `ovf` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| xing_hits | input | NCH | Hit bits of the current crossing |
| xing_drift | input | NCH*TW | Drift codes of the current crossing; channel c at [c*TW +: TW] |
| chan_mask | input | NCH | 1 disables the channel |
| trig | input | 1 | Accept trigger strobe |
| win_len | input | $clog2(MAX_WIN+1) | Crossings per event (0 is read as 1) |
| ev_ready | input | 1 | Downstream takes the head entry |
| ev_valid | output | 1 | FIFO head entry present |
| ev_hits | output | NCH | Hit bits of the head crossing |
| ev_drift | output | NCH*TW | Drift codes of the head crossing |
| ev_first | output | 1 | Head entry is the first crossing of its event |
| ev_last | output | 1 | Head entry is the last crossing of its event |
| ovf | output | 1 | Sticky event-drop flag |
| ovf_clr | input | 1 | Clears `ovf` |

## Verification
The assertions assume that `ev_ready` can fall in any cycle, that every input holds a known value, and that reset is held across at least one clock edge. Both the stall-hold check and the overflow checks depend only on those assumptions. The stimulus spaces most triggers more than one window apart so that the expected FIFO occupancy stays exact. Stalled phases and back-to-back triggers are applied on purpose, and during them the bench keeps `ev_ready` fixed so that the fill level seen at each trigger is known.

// File: rtl/otx_pkg.sv
package otx_pkg;
   typedef enum logic {
      CAP_IDLE = 1'b0,
      CAP_COPY = 1'b1
   } cap_state_t;
endpackage

// File: rtl/otx_mask.sv
module otx_mask #(
   parameter int NCH = 32,
   parameter int TW  = 6
) (
   input  logic [NCH-1:0]    raw_hits,
   input  logic [NCH*TW-1:0] raw_drift,
   input  logic [NCH-1:0]    chan_off,
   output logic [NCH-1:0]    kept_hits,
   output logic [NCH*TW-1:0] kept_drift
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign kept_hits[c]            = raw_hits[c] & ~chan_off[c];
      assign kept_drift[c*TW +: TW]  = chan_off[c] ? '0 : raw_drift[c*TW +: TW];
   end
endmodule

// File: rtl/otx_ring.sv
module otx_ring #(
   parameter int NCH = 32,
   parameter int TW  = 6,
   parameter int LAT = 160
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NCH-1:0]    wr_hits,
   input  logic [NCH*TW-1:0] wr_drift,
   output logic [NCH-1:0]    rd_hits,
   output logic [NCH*TW-1:0] rd_drift,
   output logic              primed
);
   localparam int AW = $clog2(LAT);

   logic [AW-1:0]     slot;
   logic [NCH-1:0]    hit_mem   [LAT];
   logic [NCH*TW-1:0] drift_mem [LAT];
   logic              at_end;

   assign at_end = (slot == AW'(LAT - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         slot   <= '0;
         primed <= 1'b0;
      end else begin
         slot <= at_end ? '0 : slot + 1'b1;
         if (at_end) primed <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst) begin
         hit_mem[slot]   <= wr_hits;
         drift_mem[slot] <= wr_drift;
      end
   end

   // The slot about to be overwritten holds the crossing stored LAT edges ago.
   assign rd_hits  = hit_mem[slot];
   assign rd_drift = drift_mem[slot];
endmodule

// File: rtl/otx_capture.sv
module otx_capture
   import otx_pkg::*;
#(
   parameter int MAX_WIN = 3,
   parameter int FW      = 5
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         trig,
   input  logic [$clog2(MAX_WIN+1)-1:0] win_len,
   input  logic                         primed,
   input  logic [FW-1:0]                free,
   output logic                         push,
   output logic                         push_first,
   output logic                         push_last,
   output logic                         drop,
   output logic                         busy
);
   localparam int CW = $clog2(MAX_WIN + 1);

   cap_state_t    state;
   logic [CW-1:0] remain;
   logic [CW-1:0] win_n;
   logic          start;
   logic          accept;

   always_comb begin
      if (win_len == '0)                 win_n = CW'(1);
      else if (int'(win_len) > MAX_WIN)  win_n = CW'(MAX_WIN);
      else                               win_n = win_len;
   end

   assign busy   = (state == CAP_COPY);
   assign start  = trig && primed && !busy;
   assign accept = start && (int'(free) >= int'(win_n));
   assign drop   = start && !accept;

   assign push       = accept || busy;
   assign push_first = accept;
   assign push_last  = accept ? (win_n == CW'(1)) : (remain == CW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= CAP_IDLE;
         remain <= '0;
      end else begin
         case (state)
            CAP_IDLE: begin
               if (accept && win_n > CW'(1)) begin
                  state  <= CAP_COPY;
                  remain <= win_n - 1'b1;
               end
            end
            CAP_COPY: begin
               remain <= remain - 1'b1;
               if (remain == CW'(1)) state <= CAP_IDLE;
            end
            default: state <= CAP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/otx_derand.sv
module otx_derand #(
   parameter int W     = 8,
   parameter int DEPTH = 24
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       ready,
   output logic                       valid,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] fill,
   output logic [$clog2(DEPTH+1)-1:0] free
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rptr;
   logic [AW-1:0] wptr;
   logic          pop;

   assign valid = (fill != '0);
   assign pop   = valid && ready;
   assign dout  = mem[rptr];
   assign free  = NW'(DEPTH) - fill;

   always_ff @(posedge clk) begin
      if (rst) begin
         rptr <= '0;
         wptr <= '0;
         fill <= '0;
      end else begin
         if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
         case ({push, pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push && !rst) mem[wptr] <= din;
   end
endmodule

// File: rtl/otx_lat_pipe.sv
module otx_lat_pipe #(
   parameter int NCH      = 32,
   parameter int TW       = 6,
   parameter int LAT      = 160,
   parameter int MAX_WIN  = 3,
   parameter int EV_DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NCH-1:0]               xing_hits,
   input  logic [NCH*TW-1:0]            xing_drift,
   input  logic [NCH-1:0]               chan_mask,
   input  logic                         trig,
   input  logic [$clog2(MAX_WIN+1)-1:0] win_len,
   input  logic                         ev_ready,
   output logic                         ev_valid,
   output logic [NCH-1:0]               ev_hits,
   output logic [NCH*TW-1:0]            ev_drift,
   output logic                         ev_first,
   output logic                         ev_last,
   output logic                         ovf,
   input  logic                         ovf_clr
);
   localparam int ENT = EV_DEPTH * MAX_WIN;
   localparam int FW  = $clog2(ENT + 1);
   localparam int DW  = NCH * TW;
   localparam int EW  = NCH + DW + 2;

   if (NCH < 1 || TW < 1) begin : g_bad_width
      $error("otx_lat_pipe: NCH and TW must be positive");
   end
   if (MAX_WIN < 1 || MAX_WIN >= LAT) begin : g_bad_window
      $error("otx_lat_pipe: MAX_WIN must lie in 1..LAT-1");
   end
   if (EV_DEPTH < 1) begin : g_bad_depth
      $error("otx_lat_pipe: EV_DEPTH must be at least 1");
   end

   logic [NCH-1:0] kept_hits;
   logic [DW-1:0]  kept_drift;
   logic [NCH-1:0] old_hits;
   logic [DW-1:0]  old_drift;
   logic           primed;
   logic           cap_push;
   logic           cap_first;
   logic           cap_last;
   logic           cap_drop;
   logic           cap_busy;
   logic [FW-1:0]  fill;
   logic [FW-1:0]  free;
   logic [EW-1:0]  head;

   otx_mask #(.NCH(NCH), .TW(TW)) u_mask (
      .raw_hits  (xing_hits),
      .raw_drift (xing_drift),
      .chan_off  (chan_mask),
      .kept_hits (kept_hits),
      .kept_drift(kept_drift)
   );

   otx_ring #(.NCH(NCH), .TW(TW), .LAT(LAT)) u_ring (
      .clk     (clk),
      .rst     (rst),
      .wr_hits (kept_hits),
      .wr_drift(kept_drift),
      .rd_hits (old_hits),
      .rd_drift(old_drift),
      .primed  (primed)
   );

   otx_capture #(.MAX_WIN(MAX_WIN), .FW(FW)) u_cap (
      .clk       (clk),
      .rst       (rst),
      .trig      (trig),
      .win_len   (win_len),
      .primed    (primed),
      .free      (free),
      .push      (cap_push),
      .push_first(cap_first),
      .push_last (cap_last),
      .drop      (cap_drop),
      .busy      (cap_busy)
   );

   otx_derand #(.W(EW), .DEPTH(ENT)) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (cap_push),
      .din  ({cap_first, cap_last, old_hits, old_drift}),
      .ready(ev_ready),
      .valid(ev_valid),
      .dout (head),
      .fill (fill),
      .free (free)
   );

   assign {ev_first, ev_last, ev_hits, ev_drift} = head;

   always_ff @(posedge clk) begin
      if (rst)           ovf <= 1'b0;
      else if (cap_drop) ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
   end
endmodule

// File: rtl/otx_lat_pipe_chk.sv
module otx_lat_pipe_chk #(
   parameter int NCH   = 32,
   parameter int TW    = 6,
   parameter int DEPTH = 24
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       ev_valid,
   input logic                       ev_ready,
   input logic [NCH-1:0]             ev_hits,
   input logic [NCH*TW-1:0]          ev_drift,
   input logic                       ev_first,
   input logic                       ev_last,
   input logic                       ovf,
   input logic                       ovf_clr,
   input logic                       drop,
   input logic                       push,
   input logic [$clog2(DEPTH+1)-1:0] fill
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (!ev_valid && !ovf));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_hits) && $stable(ev_drift)
                                   && $stable(ev_first) && $stable(ev_last)));

   assert_fill_bound_R8: assert property (@(posedge clk) disable iff (rst)
      int'(fill) <= DEPTH);

   assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
      push |-> (int'(fill) < DEPTH || (ev_valid && ev_ready)));

   assert_drop_sets_R9: assert property (@(posedge clk) disable iff (rst)
      drop |=> ovf);

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (ovf && !ovf_clr) |=> ovf);

   assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (rst)
      (ovf_clr && !drop) |=> !ovf);
endmodule

bind otx_lat_pipe otx_lat_pipe_chk #(.NCH(NCH), .TW(TW), .DEPTH(ENT)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .ev_valid(ev_valid),
   .ev_ready(ev_ready),
   .ev_hits (ev_hits),
   .ev_drift(ev_drift),
   .ev_first(ev_first),
   .ev_last (ev_last),
   .ovf     (ovf),
   .ovf_clr (ovf_clr),
   .drop    (cap_drop),
   .push    (cap_push),
   .fill    (fill)
);

// File: tb/otx_lat_pipe_tb.sv
module otx_lat_pipe_tb;
   localparam int NCH = 32;
   localparam int TW  = 6;
   localparam int LAT = 160;
   localparam int ENT = 24;

   typedef struct packed {
      logic [NCH-1:0]    h;
      logic [NCH*TW-1:0] d;
      logic              f;
      logic              l;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NCH-1:0]    xing_hits = '0;
   logic [NCH*TW-1:0] xing_drift = '0;
   logic [NCH-1:0]    chan_mask = '0;
   logic              trig = 1'b0;
   logic [1:0]        win_len = '0;
   logic              ev_ready = 1'b1;
   logic              ev_valid;
   logic [NCH-1:0]    ev_hits;
   logic [NCH*TW-1:0] ev_drift;
   logic              ev_first;
   logic              ev_last;
   logic              ovf;
   logic              ovf_clr = 1'b0;

   int errors = 0;
   int checks = 0;
   int cyc    = 0;
   int x      = 0;
   int busy_until = 0;
   bit m_ovf  = 1'b0;
   exp_t sb[$];
   logic [NCH-1:0]    hist_h [1024];
   logic [NCH*TW-1:0] hist_d [1024];

   always #5 clk = ~clk;

   otx_lat_pipe u_dut (
      .clk(clk), .rst(rst), .xing_hits(xing_hits), .xing_drift(xing_drift),
      .chan_mask(chan_mask), .trig(trig), .win_len(win_len), .ev_ready(ev_ready),
      .ev_valid(ev_valid), .ev_hits(ev_hits), .ev_drift(ev_drift),
      .ev_first(ev_first), .ev_last(ev_last), .ovf(ovf), .ovf_clr(ovf_clr)
   );

   function automatic logic [NCH-1:0] gen_h(input int k);
      return 32'(k * 32'h9E3779B1) ^ 32'h5A5A0F0F;
   endfunction

   function automatic logic [NCH*TW-1:0] gen_d(input int k);
      logic [NCH*TW-1:0] d;
      for (int c = 0; c < NCH; c++) d[c*TW +: TW] = 6'(k * 5 + c * 11);
      return d;
   endfunction

   function automatic logic [NCH*TW-1:0] mask_d(input logic [NCH*TW-1:0] d, input logic [NCH-1:0] m);
      logic [NCH*TW-1:0] r;
      for (int c = 0; c < NCH; c++) r[c*TW +: TW] = m[c] ? 6'd0 : d[c*TW +: TW];
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_trig(input logic [1:0] w, input bit clr);
      int n;
      n = (w == 2'd0) ? 1 : int'(w);
      if (clr) m_ovf = 1'b0;
      if (x >= LAT && x >= busy_until) begin
         if (sb.size() + n <= ENT) begin
            for (int k = 0; k < n; k++) begin
               exp_t e;
               e.h = hist_h[x - LAT + k];
               e.d = hist_d[x - LAT + k];
               e.f = (k == 0);
               e.l = (k == n - 1);
               sb.push_back(e);
            end
            busy_until = x + n;
         end else begin
            m_ovf = 1'b1;
         end
      end
   endtask

   task automatic step(input bit t, input logic [1:0] w, input bit clr);
      @(negedge clk);
      rst        = 1'b0;
      xing_hits  = gen_h(x);
      xing_drift = gen_d(x);
      trig       = t;
      win_len    = w;
      ovf_clr    = clr;
      hist_h[x]  = gen_h(x) & ~chan_mask;
      hist_d[x]  = mask_d(gen_d(x), chan_mask);
      if (t) model_trig(w, clr);
      else if (clr) m_ovf = 1'b0;
      x++;
   endtask

   task automatic idle_until(input int target);
      while (x < target) step(1'b0, 2'd0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      trig = 1'b0;
      ovf_clr = 1'b0;
      repeat (2) @(negedge clk);
      sb.delete();
      x = 0;
      busy_until = 0;
      m_ovf = 1'b0;
      chk(!ev_valid && !ovf, "R1 reset state (valid,ovf)", {ev_valid, ovf}, 2'b00);
   endtask

   // Scoreboard monitor: compares each popped crossing with the expected queue.
   always begin
      @(negedge clk);
      #2;
      if (!rst && ev_valid && ev_ready) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R3/R5/R6 unexpected crossing output", ev_hits, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(ev_hits == e.h && ev_drift == e.d, "R2/R3 crossing data (hits)", ev_hits, e.h);
            chk(ev_first == e.f && ev_last == e.l, "R7 first/last flags", {ev_first, ev_last}, {e.f, e.l});
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!ev_valid && !ovf, "R1 reset state (valid,ovf)", {ev_valid, ovf}, 2'b00);

      // R5: trigger before the ring holds LAT crossings
      idle_until(50);
      step(1'b1, 2'd3, 1'b0);
      idle_until(200);
      chk(!ev_valid && !ovf, "R5 early trigger ignored", {ev_valid, ovf}, 2'b00);

      // R3/R4: windows of each length, including code 0
      step(1'b1, 2'd1, 1'b0); idle_until(210);
      step(1'b1, 2'd2, 1'b0); idle_until(220);
      step(1'b1, 2'd3, 1'b0); idle_until(230);
      step(1'b1, 2'd0, 1'b0); idle_until(240);
      // R6: triggers during the copy are ignored
      step(1'b1, 2'd3, 1'b0);
      step(1'b1, 2'd1, 1'b0);
      step(1'b1, 2'd2, 1'b0);
      idle_until(250);
      chan_mask = 32'h0000_F00F;             // R2 masking from crossing 250 on
      idle_until(300);
      step(1'b1, 2'd2, 1'b0); idle_until(420);
      step(1'b1, 2'd3, 1'b0); idle_until(430);
      chk(sb.size() == 0 && !ev_valid, "R3 all windows delivered", sb.size(), 0);
      chk(ovf == m_ovf, "R9 no overflow in flow", ovf, m_ovf);

      // R8/R9: stall the output and fill the FIFO
      ev_ready = 1'b0;
      idle_until(440);
      for (int i = 0; i < 9; i++) begin
         step(1'b1, 2'd3, 1'b0);
         idle_until(445 + 5 * i);
      end
      step(1'b0, 2'd0, 1'b0);
      chk(ovf == 1'b1 && m_ovf, "R9 overflow on full FIFO", ovf, 1);
      chk(sb.size() == ENT, "R8 FIFO holds EV_DEPTH*MAX_WIN crossings", sb.size(), ENT);
      chk(ev_valid && ev_hits == sb[0].h && ev_first, "R8 head held during stall", ev_hits, sb[0].h);
      idle_until(490);
      chk(ev_valid && ev_drift == sb[0].d, "R8 head drift stable", ev_drift, sb[0].d);
      step(1'b0, 2'd0, 1'b1);
      step(1'b0, 2'd0, 1'b0);
      chk(ovf == 1'b0, "R10 clear overflow", ovf, 0);
      idle_until(495);
      step(1'b1, 2'd1, 1'b1);                // drop and clear together
      step(1'b0, 2'd0, 1'b0);
      chk(ovf == 1'b1, "R10 drop wins over clear", ovf, 1);
      step(1'b0, 2'd0, 1'b1);
      step(1'b0, 2'd0, 1'b0);
      chk(ovf == 1'b0, "R10 second clear", ovf, 0);
      ev_ready = 1'b1;
      idle_until(560);
      chk(sb.size() == 0 && !ev_valid, "R9 dropped events absent", sb.size(), 0);

      // R1: reset with queued data, then R5 after reset
      ev_ready = 1'b0;
      idle_until(570);
      step(1'b1, 2'd2, 1'b0);
      idle_until(575);
      chk(ev_valid == 1'b1, "R8 event queued before reset", ev_valid, 1);
      do_reset();
      ev_ready = 1'b1;
      idle_until(10);
      step(1'b1, 2'd3, 1'b0);
      idle_until(30);
      chk(!ev_valid && !ovf, "R5 ring not primed after reset", {ev_valid, ovf}, 2'b00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule